// File: doc/BRIEF.md
# Square Tone Channel with Frequency Sweep

This block makes a square-wave tone. Software writes five byte-wide control registers. A frequency timer runs at a rate set by an 11-bit frequency word. Each time it expires, a 3-bit phase counter advances through one of four 8-step duty waveforms. When the waveform is high, the 4-bit output amplitude equals the current envelope volume. When it is low, the amplitude is zero.

An external frame sequencer supplies three single-cycle tick inputs:

- The length tick counts a length counter down. When that counter empties, the channel is silenced.
- The envelope tick moves the volume up or down.
- The sweep tick periodically recomputes the frequency from a shadow copy. The new frequency is written back into the frequency registers, and the channel is switched off if the result would exceed the 11-bit range.

A trigger write restarts the channel and reloads all of its state. A digital-to-analog gate, derived from the envelope register, can force the output to a fixed "converter off" level.

A trigger takes effect on the clock edge after the edge that writes it. Register writes act on the edge where wrEn is high. Ticks act on the edge where they are high.

Top module: `sqtone_top`

## Requirements
- R1: After reset, chanOn is 0 and amp is 0. Until the first trigger, the frequency timer never advances the phase, and the channel stays silent whatever values the registers are given.
- R2: The frequency is {reg4[2:0], reg3}. After a trigger, the phase starts at 0 and advances by one, modulo 8, every (2048 - frequency) * 4 clocks.
- R3: reg1[7:6] selects the duty waveform. The waveform is high when bit `phase` of the pattern is 1. The patterns are 8'h01 for 0, 8'h03 for 1, 8'h0F for 2 and 8'h3F for 3. While the channel is on and the waveform is high, amp equals the volume; otherwise amp is 0.
- R4: The converter is on only when reg2[7:3] is nonzero. While it is off, amp equals the DAC_OFF_AMP parameter (default 0). A write to reg2 with bits 7:3 all zero disables the channel, and a trigger while the converter is off leaves it disabled.
- R5: A trigger loads the volume from reg2[7:4]. reg2[3] set means up, clear means down. The volume steps once every P envelope ticks, where P is reg2[2:0] and a value of 0 counts as 8. The volume saturates at 0 and at 15.
- R6: A write to reg1 sets the length counter to 64 - reg1[5:0]. When reg4[6] is 1, each length tick decrements a nonzero counter, and reaching 0 disables the channel. When reg4[6] is 0, length ticks have no effect. A trigger with the counter at 0 reloads it with 64.
- R7: reg0 holds the sweep settings: bits 6:4 are the period, bit 3 selects subtraction and bits 2:0 are the shift.
  - Every period sweep ticks, the new value is computed as shadow ± (shadow >> shift).
  - If shift is nonzero, that value replaces both the shadow and the frequency registers.
  - A period of 0 gives no recalculation.
- R8: A sweep result above 2047 disables the channel. At a trigger with a nonzero shift, the same check is made on the frequency, and a failing check leaves the channel disabled.
- R9: Writing reg4 with bit 7 set restarts the channel:
  - the phase returns to 0 and the timer reloads;
  - the volume and the shadow frequency reload;
  - the channel is enabled, unless R4 or R8 prevents it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register index 0 to 4 |
| wrData | input | 8 | Register write data |
| lengthTick | input | 1 | Length counter step |
| envTick | input | 1 | Envelope step |
| sweepTick | input | 1 | Sweep step |
| amp | output | 4 | Output amplitude |
| chanOn | output | 1 | Channel enabled flag |

## Verification
The bench measures the waveform cycle by cycle for each duty and for several timer periods. A timer that reloaded off by one, or a wrong pattern bit, would show up as an amplitude change one clock early or late.

The bench tests envelope saturation at both ends and the rule that a period of 0 counts as 8. A volume that wrapped, or an envelope period of 0 that stepped every tick, would produce the wrong level.

For the sweep, the bench retriggers after a sweep and measures the new timer period. A design that failed to write the swept value back into the frequency registers would keep the old, slower period. The bench also covers overflow in the sweep and at the trigger, subtraction that never overflows, a sweep period of 2, and a sweep period of 0. A design that got these wrong would leave the channel on when it should be off, or the reverse.

The bench checks that the length counter reloads 64 when it is empty at a trigger, and that length ticks are ignored when length is not enabled. A wrong design would silence the channel early or never.

// File: rtl/sqtone_pkg.sv
package sqtone_pkg;
  localparam int FREQ_W   = 11;
  localparam int VOL_W    = 4;
  localparam int LEN_MAX  = 64;
  localparam int LEN_W    = $clog2(LEN_MAX + 1);
  localparam int DUTY_W   = 2;
  localparam int PHASE_W  = 3;
  localparam int NUM_REGS = 5;

  typedef struct packed {
    logic              restart;
    logic              audible;
    logic              dacOn;
    logic [DUTY_W-1:0] duty;
    logic [VOL_W-1:0]  volume;
    logic [FREQ_W-1:0] freq;
  } ctl2dp_t;
endpackage

// File: rtl/sqtone_ctrl.sv
module sqtone_ctrl
  import sqtone_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic    lengthTick,
  input  logic    envTick,
  input  logic    sweepTick,
  output ctl2dp_t ctl,
  output logic    chanOn
);
  localparam logic [LEN_W-1:0] LEN_FULL = LEN_W'(LEN_MAX);

  logic [2:0] swPeriod, swShift;
  logic       swNeg;
  logic [DUTY_W-1:0] duty;
  logic [VOL_W-1:0]  envInit;
  logic       envUp;
  logic [2:0] envRaw;
  logic [FREQ_W-1:0] freq;
  logic       lenEn;

  logic       trigPend;
  logic       enabled;
  logic [VOL_W-1:0]  volume;
  logic [3:0] envCnt;
  logic [LEN_W-1:0] lenCnt;
  logic [FREQ_W-1:0] shadow;
  logic [3:0] sweepCnt;
  logic       sweepOn;

  function automatic logic [FREQ_W:0] sweepNext(input logic [FREQ_W-1:0] base,
                                                 input logic [2:0] sh,
                                                 input logic neg);
    logic [FREQ_W:0] b, dl;
    b  = {1'b0, base};
    dl = b >> sh;
    return neg ? (b - dl) : (b + dl);
  endfunction

  logic [FREQ_W:0] sum12, trigSum;
  logic dacOn, sweepFire, sweepCalc, sweepWrite, trigOver;
  logic [3:0] envReload, swReload;
  logic wrSel [NUM_REGS];

  always_comb begin
    for (int k = 0; k < NUM_REGS; k++) wrSel[k] = wrEn && (wrAddr == 3'(k));
  end

  assign dacOn      = |{envInit, envUp};
  assign sum12      = sweepNext(shadow, swShift, swNeg);
  assign trigSum    = sweepNext(freq, swShift, swNeg);
  assign trigOver   = (swShift != 3'd0) && trigSum[FREQ_W];
  assign envReload  = (envRaw == 3'd0) ? 4'd8 : {1'b0, envRaw};
  assign swReload   = (swPeriod == 3'd0) ? 4'd8 : {1'b0, swPeriod};
  assign sweepFire  = !trigPend && sweepTick && sweepOn && enabled && (sweepCnt == 4'd1);
  assign sweepCalc  = sweepFire && (swPeriod != 3'd0);
  assign sweepWrite = sweepCalc && !sum12[FREQ_W] && (swShift != 3'd0);

  // Register fields; a bus write wins over a sweep writeback in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      swPeriod <= '0; swNeg <= 1'b0; swShift <= '0;
      duty <= '0; envInit <= '0; envUp <= 1'b0; envRaw <= '0;
      freq <= '0; lenEn <= 1'b0; trigPend <= 1'b0;
    end else begin
      trigPend <= wrSel[4] && wrData[7];
      if (sweepWrite) freq <= sum12[FREQ_W-1:0];
      if (wrSel[0]) begin
        swPeriod <= wrData[6:4]; swNeg <= wrData[3]; swShift <= wrData[2:0];
      end
      if (wrSel[1]) duty <= wrData[7:6];
      if (wrSel[2]) begin
        envInit <= wrData[7:4]; envUp <= wrData[3]; envRaw <= wrData[2:0];
      end
      if (wrSel[3]) freq[7:0] <= wrData;
      if (wrSel[4]) begin
        freq[FREQ_W-1:8] <= wrData[2:0]; lenEn <= wrData[6];
      end
    end
  end

  // Channel state: enable, envelope, length, sweep
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enabled <= 1'b0; volume <= '0; envCnt <= '0; lenCnt <= '0;
      shadow <= '0; sweepCnt <= '0; sweepOn <= 1'b0;
    end else begin
      if (trigPend) begin
        enabled  <= dacOn && !trigOver;
        volume   <= envInit;
        envCnt   <= envReload;
        if (lenCnt == '0) lenCnt <= LEN_FULL;
        shadow   <= freq;
        sweepCnt <= swReload;
        sweepOn  <= (swPeriod != 3'd0) || (swShift != 3'd0);
      end else begin
        if (envTick && enabled) begin
          if (envCnt <= 4'd1) begin
            envCnt <= envReload;
            if (envUp && volume != 4'hF) volume <= volume + 4'd1;
            else if (!envUp && volume != 4'h0) volume <= volume - 4'd1;
          end else begin
            envCnt <= envCnt - 4'd1;
          end
        end
        if (lengthTick && lenEn && lenCnt != '0) begin
          lenCnt <= lenCnt - LEN_W'(1);
          if (lenCnt == LEN_W'(1)) enabled <= 1'b0;
        end
        if (sweepTick && sweepOn && enabled) begin
          if (sweepCnt <= 4'd1) sweepCnt <= swReload;
          else sweepCnt <= sweepCnt - 4'd1;
        end
        if (sweepCalc && sum12[FREQ_W]) enabled <= 1'b0;
        if (sweepWrite) shadow <= sum12[FREQ_W-1:0];
      end
      if (wrSel[1]) lenCnt <= LEN_FULL - LEN_W'(wrData[5:0]);
      if (wrSel[2] && wrData[7:3] == 5'd0) enabled <= 1'b0;
    end
  end

  always_comb begin
    ctl.restart = trigPend;
    ctl.audible = enabled;
    ctl.dacOn   = dacOn;
    ctl.duty    = duty;
    ctl.volume  = volume;
    ctl.freq    = freq;
  end
  assign chanOn = enabled;

  assert_vol_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(trigPend) && volume != $past(volume)) |->
      ($past(envTick) && (volume == $past(volume) + 4'd1 || volume == $past(volume) - 4'd1)));

  assert_len_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lenCnt != $past(lenCnt) && !$past(trigPend) && !$past(wrSel[1])) |->
      ($past(lengthTick) && lenCnt == $past(lenCnt) - LEN_W'(1)));

  assert_dac_kill_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrSel[2] && wrData[7:3] == 5'd0) |-> !chanOn);

  assert_over_kill_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(sweepCalc && sum12[FREQ_W]) |-> !chanOn);

  assert_trig_vol_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(trigPend) |-> volume == $past(envInit));
endmodule

// File: rtl/sqtone_dp.sv
module sqtone_dp
  import sqtone_pkg::*;
#(
  parameter int TIMER_MUL = 4,
  parameter logic [VOL_W-1:0] DAC_OFF_AMP = '0
) (
  input  logic    clk,
  input  logic    rstN,
  input  ctl2dp_t ctl,
  output logic [VOL_W-1:0] amp
);
  localparam int FULL  = 1 << FREQ_W;
  localparam int CNT_W = $clog2(FULL * TIMER_MUL + 1);

  logic [CNT_W-1:0]   cnt, period;
  logic [PHASE_W-1:0] phase;
  logic               timerLive;
  logic               waveHigh;

  function automatic logic dutyBit(input logic [DUTY_W-1:0] d, input logic [PHASE_W-1:0] p);
    logic [7:0] pat;
    case (d)
      2'd0:    pat = 8'h01;
      2'd1:    pat = 8'h03;
      2'd2:    pat = 8'h0F;
      default: pat = 8'h3F;
    endcase
    return pat[p];
  endfunction

  assign period   = CNT_W'((FULL - int'(ctl.freq)) * TIMER_MUL);
  assign waveHigh = dutyBit(ctl.duty, phase);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0; phase <= '0; timerLive <= 1'b0;
    end else if (ctl.restart) begin
      cnt <= period; phase <= '0; timerLive <= 1'b1;
    end else if (timerLive) begin
      if (cnt <= CNT_W'(1)) begin
        cnt   <= period;
        phase <= phase + PHASE_W'(1);
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  always_comb begin
    if (!ctl.dacOn)                      amp = DAC_OFF_AMP;
    else if (ctl.audible && waveHigh)    amp = ctl.volume;
    else                                 amp = '0;
  end

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !timerLive |-> (phase == '0));

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phase != $past(phase)) |->
      (phase == $past(phase) + PHASE_W'(1) || (phase == '0 && $past(ctl.restart))));
endmodule

// File: rtl/sqtone_top.sv
module sqtone_top
  import sqtone_pkg::*;
#(
  parameter int TIMER_MUL = 4,
  parameter logic [3:0] DAC_OFF_AMP = 4'd0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic       lengthTick,
  input  logic       envTick,
  input  logic       sweepTick,
  output logic [3:0] amp,
  output logic       chanOn
);
  ctl2dp_t ctl;

  sqtone_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .lengthTick(lengthTick), .envTick(envTick), .sweepTick(sweepTick),
    .ctl(ctl), .chanOn(chanOn)
  );

  sqtone_dp #(.TIMER_MUL(TIMER_MUL), .DAC_OFF_AMP(DAC_OFF_AMP)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .amp(amp)
  );
endmodule

// File: tb/sqtone_top_test.sv
module sqtone_top_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic lengthTick = 1'b0, envTick = 1'b0, sweepTick = 1'b0;
  logic [3:0] amp;
  logic chanOn;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sqtone_top uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .lengthTick(lengthTick), .envTick(envTick), .sweepTick(sweepTick),
    .amp(amp), .chanOn(chanOn)
  );

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    step(1);
    wrEn = 1'b0;
  endtask

  // Trigger write, then one more edge so the restart has taken effect
  task automatic trigger(input logic [2:0] hi, input logic le);
    wr(3'd4, {1'b1, le, 3'b000, hi});
    step(1);
  endtask

  task automatic pulseEnv(input int n);
    repeat (n) begin envTick = 1'b1; step(1); envTick = 1'b0; end
  endtask
  task automatic pulseLen(input int n);
    repeat (n) begin lengthTick = 1'b1; step(1); lengthTick = 1'b0; end
  endtask
  task automatic pulseSweep(input int n);
    repeat (n) begin sweepTick = 1'b1; step(1); sweepTick = 1'b0; end
  endtask

  task automatic chkAmp(input logic [3:0] exp, input string tag);
    checks++;
    if (amp !== exp) begin
      failures++;
      $display("FAIL %s amp=%0d expected %0d at %0t", tag, amp, exp, $time);
    end
  endtask

  task automatic chkOn(input logic exp, input string tag);
    checks++;
    if (chanOn !== exp) begin
      failures++;
      $display("FAIL %s chanOn=%0d expected %0d at %0t", tag, chanOn, exp, $time);
    end
  endtask

  function automatic logic expBit(input int d, input int p);
    logic [7:0] pat;
    case (d)
      0: pat = 8'h01;
      1: pat = 8'h03;
      2: pat = 8'h0F;
      default: pat = 8'h3F;
    endcase
    return pat[p];
  endfunction

  // Called one edge after the restart took effect (phase 0)
  task automatic checkWave(input int per, input int d, input logic [3:0] vol, input string tag);
    for (int k = 0; k < 8 * per; k++) begin
      chkAmp(expBit(d, (k / per) % 8) ? vol : 4'd0, tag);
      step(1);
    end
  endtask

  task automatic testReset();
    chkAmp(4'd0, "R1 reset amp");
    chkOn(1'b0, "R1 reset chanOn");
    wr(3'd2, 8'hF0); wr(3'd1, 8'hC0); wr(3'd3, 8'hFF); wr(3'd4, 8'h07);
    step(20);
    chkOn(1'b0, "R1 no trigger chanOn");
    chkAmp(4'd0, "R1 no trigger amp");
  endtask

  task automatic testDuty();
    wr(3'd0, 8'h00); wr(3'd2, 8'hF0); wr(3'd3, 8'hFF);
    for (int d = 0; d < 4; d++) begin
      wr(3'd1, 8'(d << 6));
      trigger(3'h7, 1'b0);
      checkWave(4, d, 4'd15, "R3 duty");
    end
    wr(3'd1, 8'h80); wr(3'd3, 8'hFE);
    trigger(3'h7, 1'b0);
    checkWave(8, 2, 4'd15, "R2 period 8");
    wr(3'd1, 8'h40); wr(3'd3, 8'hFD);
    trigger(3'h7, 1'b0);
    checkWave(12, 1, 4'd15, "R2 period 12");
  endtask

  task automatic testRetrigger();
    wr(3'd1, 8'h00); wr(3'd2, 8'hF0); wr(3'd3, 8'hFF);
    trigger(3'h7, 1'b0);
    step(6);
    chkAmp(4'd0, "R9 mid waveform low");
    wr(3'd2, 8'h90);
    trigger(3'h7, 1'b0);
    chkAmp(4'd9, "R9 restart phase and volume");
    chkOn(1'b1, "R9 restart enabled");
  endtask

  task automatic testEnvelope();
    wr(3'd0, 8'h00); wr(3'd3, 8'h00);
    wr(3'd2, 8'hA2); trigger(3'h0, 1'b0);
    chkAmp(4'd10, "R5 initial volume");
    pulseEnv(1); chkAmp(4'd10, "R5 period 2 first tick");
    pulseEnv(1); chkAmp(4'd9, "R5 period 2 step down");
    pulseEnv(2); chkAmp(4'd8, "R5 period 2 second step");
    wr(3'd2, 8'hE9); trigger(3'h0, 1'b0);
    pulseEnv(1); chkAmp(4'd15, "R5 step up");
    pulseEnv(1); chkAmp(4'd15, "R5 saturate 15");
    wr(3'd2, 8'h11); trigger(3'h0, 1'b0);
    pulseEnv(1); chkAmp(4'd0, "R5 step to 0");
    pulseEnv(1); chkAmp(4'd0, "R5 saturate 0");
    chkOn(1'b1, "R5 still enabled at volume 0");
    wr(3'd2, 8'h50); trigger(3'h0, 1'b0);
    pulseEnv(7); chkAmp(4'd5, "R5 period 0 after 7 ticks");
    pulseEnv(1); chkAmp(4'd4, "R5 period 0 acts as 8");
  endtask

  task automatic testDac();
    wr(3'd0, 8'h00); wr(3'd3, 8'h00);
    wr(3'd2, 8'h07); trigger(3'h0, 1'b0);
    chkOn(1'b0, "R4 trigger with converter off");
    chkAmp(4'd0, "R4 converter off amp");
    wr(3'd2, 8'hF0); trigger(3'h0, 1'b0);
    chkAmp(4'd15, "R4 converter on amp");
    wr(3'd2, 8'h00);
    chkOn(1'b0, "R4 converter off write disables");
    chkAmp(4'd0, "R4 converter off after write");
  endtask

  task automatic testLength();
    wr(3'd0, 8'h00); wr(3'd2, 8'hF0); wr(3'd1, 8'h3E); wr(3'd3, 8'h00);
    trigger(3'h0, 1'b1);
    chkOn(1'b1, "R6 on after trigger");
    pulseLen(1); chkOn(1'b1, "R6 one tick left");
    pulseLen(1); chkOn(1'b0, "R6 length expired");
    chkAmp(4'd0, "R6 silent after expiry");
    trigger(3'h0, 1'b1);
    pulseLen(63); chkOn(1'b1, "R6 reload 64 after 63 ticks");
    pulseLen(1);  chkOn(1'b0, "R6 reload 64 expires");
    trigger(3'h0, 1'b0);
    pulseLen(70); chkOn(1'b1, "R6 ticks ignored without length enable");
  endtask

  task automatic testSweep();
    wr(3'd1, 8'h00); wr(3'd2, 8'hF0);
    wr(3'd0, 8'h11); wr(3'd3, 8'h54); trigger(3'h5, 1'b0);
    chkOn(1'b1, "R8 trigger check passes");
    pulseSweep(1); chkOn(1'b1, "R7 sweep to 2046");
    pulseSweep(1); chkOn(1'b0, "R8 sweep overflow disables");
    wr(3'd0, 8'h10); trigger(3'h7, 1'b0);
    checkWave(8, 0, 4'd15, "R7 swept frequency written back");
    wr(3'd0, 8'h19); wr(3'd3, 8'hFE); trigger(3'h7, 1'b0);
    pulseSweep(3); chkOn(1'b1, "R7 subtract never overflows");
    wr(3'd0, 8'h21); wr(3'd3, 8'h54); trigger(3'h5, 1'b0);
    pulseSweep(3); chkOn(1'b1, "R7 period 2 after 3 ticks");
    pulseSweep(1); chkOn(1'b0, "R7 period 2 overflow on 4th tick");
    wr(3'd0, 8'h01); wr(3'd3, 8'h00); trigger(3'h4, 1'b0);
    pulseSweep(16); chkOn(1'b1, "R7 period 0 no recalculation");
    wr(3'd0, 8'h01); wr(3'd3, 8'hDC); trigger(3'h5, 1'b0);
    chkOn(1'b0, "R8 trigger overflow leaves off");
    chkAmp(4'd0, "R8 trigger overflow amp");
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    testReset();
    testDuty();
    testRetrigger();
    testEnvelope();
    testDac();
    testLength();
    testSweep();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule